// File: doc/BRIEF.md
# Interrupt-Triggered Four-Channel Transfer Engine

This block moves data between memory locations on behalf of peripherals, one unit per peripheral interrupt. Each of its four channels is armed by writing a trigger vector that names one interrupt source. It is also given a source address, a destination address, a unit count and a mode. When the named source has a pending request, the engine claims that request and clears its pending flag. It then copies one unit of 1, 2 or 4 bytes over a valid/ready memory port and decrements the channel's count.

When the count reaches zero, the channel raises its own completion interrupt and disarms itself by zeroing its trigger vector. A pending source that no armed channel names is passed on unchanged to the normal interrupt path. New work is held off while the interrupt mask is at its top level or while the system is in standby. Requests that are held off this way stay pending and are serviced later.

The memory port is a single valid/ready request channel. A read returns its data in the cycle that the read is accepted. The engine raises `mem_valid` and holds address, direction, size and write data unchanged until it samples `mem_ready` high. A beat completes on any rising edge where both are high. The memory side may stall a beat for any number of cycles.

Top module: `irq_dma_engine`

## Requirements
- R1: There are four channels. A channel whose trigger vector is zero is disarmed. A nonzero vector v makes the channel request service whenever `irq_pend[v]` is high. The configuration written through `cfg_*` is read back through `rd_vec`/`rd_cnt` for the channel selected by `rd_ch`.
- R2: While `int_mask` equals 7, no new service is accepted. The request stays pending and is serviced once the mask drops.
- R3: While `standby` is high, no new service is accepted. The request stays pending and is serviced after standby ends.
- R4: One cycle after a service is accepted, `irq_clr` pulses for exactly one cycle, with only the bit of the triggering source set. A burst produces a single pulse.
- R5: Each unit is one read beat at the source address followed by one write beat at the destination. `mem_size` encodes the unit: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Data are right-justified and little-endian, with the lowest-addressed byte in bits 7:0. After each unit, each address advances by the unit size if its increment bit is set and otherwise stays fixed.
- R6: Each unit decrements the channel count by one. If the result is nonzero and burst is off, service ends with no completion interrupt.
- R7: When the count reaches zero, that channel's `done_irq` bit pulses for one cycle, in the cycle after the final write beat, and its trigger vector becomes zero.
- R8: With burst on, one accepted request copies units back to back until the count reaches zero.
- R9: When several channels request in the same cycle, the lowest-numbered channel is served first. The other requests are served afterwards.
- R10: Address registers are 32 bits wide. Only bits 23:0 appear on `mem_addr`, and the upper byte has no effect on the bus.
- R11: `irq_fwd[s]` equals `irq_pend[s]` for every source that no channel names as its nonzero vector. It is zero for sources that a channel names.
- R12: `busy` rises in the cycle after acceptance and stays high until the final write beat of the service completes.
- R13: Once `mem_valid` is high, it stays high with `mem_addr`, `mem_write`, `mem_size` and `mem_wdata` unchanged until `mem_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | load channel `cfg_ch` with all `cfg_*` fields |
| cfg_ch | input | 2 | channel to configure |
| cfg_vec | input | VEC_W | trigger vector (0 = disarmed) |
| cfg_src | input | 32 | source address |
| cfg_dst | input | 32 | destination address |
| cfg_cnt | input | CNT_W | number of units |
| cfg_size | input | 2 | unit size code |
| cfg_src_inc | input | 1 | advance source address per unit |
| cfg_dst_inc | input | 1 | advance destination address per unit |
| cfg_burst | input | 1 | run all units on one request |
| rd_ch | input | 2 | channel shown on readback |
| rd_vec | output | VEC_W | trigger vector of `rd_ch` |
| rd_cnt | output | CNT_W | remaining count of `rd_ch` |
| irq_pend | input | NSRC | pending flags of interrupt sources |
| irq_clr | output | NSRC | one-cycle clear of a claimed pending flag |
| irq_fwd | output | NSRC | pending flags passed to the normal interrupt path |
| int_mask | input | 3 | current interrupt mask level |
| standby | input | 1 | system standby; holds new service |
| mem_valid | output | 1 | memory beat request |
| mem_ready | input | 1 | memory accepts the beat |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 24 | byte address |
| mem_size | output | 2 | unit size code of the beat |
| mem_wdata | output | 32 | right-justified write data |
| mem_rdata | input | 32 | right-justified read data, valid with `mem_ready` on a read |
| busy | output | 1 | service in progress |
| done_irq | output | 4 | per-channel completion pulse |

## Verification
The assertions take several things for granted about the inputs.
- Each pending flag is a level that the interrupt model clears on `irq_clr`.
- Software does not rewrite a channel while that channel is being serviced.
- Counts are armed nonzero.
- Read data is meaningful in the cycle that `mem_ready` accepts a read.

The bench keeps to these rules. It arms channels only while `busy` is low, uses counts of one or more, models pending flags as set-on-raise and clear-on-`irq_clr` registers, and returns read data from a byte array indexed by the presented address. Its ready signal either stays high or stalls periodically, and it never depends on `mem_valid`.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = 2;
  localparam int AW     = 32;
  localparam int BUS_AW = 24;
  localparam int DW     = 32;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} xfer_st_e;

  typedef struct packed {
    logic       burst;
    logic       src_inc;
    logic       dst_inc;
    logic [1:0] size;
  } ch_mode_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] unit_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [VEC_W-1:0]  wr_vec,
  input  logic [AW-1:0]     wr_src,
  input  logic [AW-1:0]     wr_dst,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  ch_mode_t          wr_mode,
  input  logic              step,
  output logic [VEC_W-1:0]  vec,
  output logic [BUS_AW-1:0] src_bus,
  output logic [BUS_AW-1:0] dst_bus,
  output logic [CNT_W-1:0]  cnt,
  output ch_mode_t          mode
);
  logic [AW-1:0] src_q, dst_q;
  logic [AW-1:0] stride;

  assign stride  = AW'(unit_bytes(mode.size));
  assign src_bus = src_q[BUS_AW-1:0];
  assign dst_bus = dst_q[BUS_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec   <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt   <= '0;
      mode  <= '0;
    end else if (wr_en) begin
      vec   <= wr_vec;
      src_q <= wr_src;
      dst_q <= wr_dst;
      cnt   <= wr_cnt;
      mode  <= wr_mode;
    end else if (step) begin
      cnt <= cnt - CNT_W'(1);
      if (mode.src_inc) src_q <= src_q + stride;
      if (mode.dst_inc) dst_q <= dst_q + stride;
      if (cnt == CNT_W'(1)) vec <= '0;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1)))); // R6
  AST_DISARM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && cnt == CNT_W'(1)) |=> (vec == '0)); // R7
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
  import dma_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5
) (
  input  logic [NCH-1:0][VEC_W-1:0] vec,
  input  logic [NSRC-1:0]           pend,
  output logic [NCH-1:0]            req,
  output logic                      req_any,
  output logic [CH_W-1:0]           grant_ch,
  output logic [VEC_W-1:0]          grant_src,
  output logic [NSRC-1:0]           fwd
);
  logic [NSRC-1:0] claimed;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      req[c] = (vec[c] != '0) && (int'(vec[c]) < NSRC) && pend[vec[c]];
    end
  end

  // fixed priority: channel 0 highest
  always_comb begin
    grant_ch = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (req[c]) grant_ch = CH_W'(c);
    end
    grant_src = vec[grant_ch];
    req_any   = |req;
  end

  always_comb begin
    claimed = '0;
    for (int c = 0; c < NCH; c++) begin
      for (int s = 1; s < NSRC; s++) begin
        if (int'(vec[c]) == s) claimed[s] = 1'b1;
      end
    end
    fwd = pend & ~claimed;
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_any,
  input  logic [CH_W-1:0]   grant_ch,
  input  logic [VEC_W-1:0]  grant_src,
  input  logic              standby,
  input  logic [2:0]        int_mask,
  input  logic [BUS_AW-1:0] act_src,
  input  logic [BUS_AW-1:0] act_dst,
  input  logic [CNT_W-1:0]  act_cnt,
  input  logic [1:0]        act_size,
  input  logic              act_burst,
  output logic [CH_W-1:0]   act_ch,
  output logic              step,
  output logic [NSRC-1:0]   irq_clr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [BUS_AW-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic [NCH-1:0]    done_irq
);
  xfer_st_e      st;
  logic [DW-1:0] rbuf;
  logic          accept;
  logic          last_unit;

  assign accept    = (st == ST_IDLE) && req_any && !standby && (int_mask != 3'd7);
  assign last_unit = (act_cnt == CNT_W'(1));
  assign step      = (st == ST_WR) && mem_ready;
  assign busy      = (st != ST_IDLE);
  assign mem_valid = (st == ST_RD) || (st == ST_WR);
  assign mem_write = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? act_dst : act_src;
  assign mem_size  = act_size;
  assign mem_wdata = (st == ST_WR) ? rbuf : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      act_ch   <= '0;
      rbuf     <= '0;
      irq_clr  <= '0;
      done_irq <= '0;
    end else begin
      irq_clr  <= '0;
      done_irq <= '0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            act_ch             <= grant_ch;
            irq_clr[grant_src] <= 1'b1;
            st                 <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            rbuf <= mem_rdata & unit_mask(act_size);
            st   <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            if (last_unit) begin
              done_irq[act_ch] <= 1'b1;
              st               <= ST_IDLE;
            end else if (act_burst) begin
              st <= ST_RD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && int_mask == 3'd7) |=> (st == ST_IDLE)); // R2
  AST_HOLD_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && standby) |=> (st == ST_IDLE)); // R3
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clr)); // R4
  AST_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_clr) |-> busy); // R12
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_size) && $stable(mem_wdata))); // R13
  AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_irq)); // R7
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_irq) |-> ($past(mem_valid && mem_write && mem_ready) && !busy)); // R7
endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine
  import dma_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = $clog2(NSRC),
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_ch,
  input  logic [VEC_W-1:0]  cfg_vec,
  input  logic [31:0]       cfg_src,
  input  logic [31:0]       cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              cfg_burst,
  input  logic [1:0]        rd_ch,
  output logic [VEC_W-1:0]  rd_vec,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [NSRC-1:0]   irq_pend,
  output logic [NSRC-1:0]   irq_clr,
  output logic [NSRC-1:0]   irq_fwd,
  input  logic [2:0]        int_mask,
  input  logic              standby,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [23:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [3:0]        done_irq
);
  logic [NCH-1:0][VEC_W-1:0]  vec_a;
  logic [NCH-1:0][BUS_AW-1:0] src_a, dst_a;
  logic [NCH-1:0][CNT_W-1:0]  cnt_a;
  ch_mode_t                   mode_a [NCH];
  logic [NCH-1:0]             req;
  logic                       req_any;
  logic [CH_W-1:0]            grant_ch, act_ch;
  logic [VEC_W-1:0]           grant_src;
  logic                       step;
  ch_mode_t                   cfg_mode;

  assign cfg_mode = '{burst: cfg_burst, src_inc: cfg_src_inc, dst_inc: cfg_dst_inc, size: cfg_size};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_regs #(.VEC_W(VEC_W), .CNT_W(CNT_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_ch == CH_W'(c))),
      .wr_vec  (cfg_vec),
      .wr_src  (cfg_src),
      .wr_dst  (cfg_dst),
      .wr_cnt  (cfg_cnt),
      .wr_mode (cfg_mode),
      .step    (step && (act_ch == CH_W'(c))),
      .vec     (vec_a[c]),
      .src_bus (src_a[c]),
      .dst_bus (dst_a[c]),
      .cnt     (cnt_a[c]),
      .mode    (mode_a[c])
    );

    AST_FWD_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_a[c] != '0) |-> !irq_fwd[vec_a[c]]); // R11
  end

  dma_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) i_arb (
    .vec       (vec_a),
    .pend      (irq_pend),
    .req       (req),
    .req_any   (req_any),
    .grant_ch  (grant_ch),
    .grant_src (grant_src),
    .fwd       (irq_fwd)
  );

  dma_xfer_fsm #(.NSRC(NSRC), .VEC_W(VEC_W), .CNT_W(CNT_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_any   (req_any),
    .grant_ch  (grant_ch),
    .grant_src (grant_src),
    .standby   (standby),
    .int_mask  (int_mask),
    .act_src   (src_a[act_ch]),
    .act_dst   (dst_a[act_ch]),
    .act_cnt   (cnt_a[act_ch]),
    .act_size  (mode_a[act_ch].size),
    .act_burst (mode_a[act_ch].burst),
    .act_ch    (act_ch),
    .step      (step),
    .irq_clr   (irq_clr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done_irq  (done_irq)
  );

  assign rd_vec = vec_a[rd_ch];
  assign rd_cnt = cnt_a[rd_ch];

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> (req[grant_ch] && ((req & ((NCH'(1) << grant_ch) - NCH'(1))) == '0))); // R9
endmodule

// File: tb/test_irq_dma_engine.sv
module test_irq_dma_engine;
  localparam int NSRC  = 32;
  localparam int VEC_W = 5;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cfg_we = 0;
  logic [1:0]       cfg_ch = 0;
  logic [VEC_W-1:0] cfg_vec = 0;
  logic [31:0]      cfg_src = 0, cfg_dst = 0;
  logic [CNT_W-1:0] cfg_cnt = 0;
  logic [1:0]       cfg_size = 0;
  logic             cfg_src_inc = 0, cfg_dst_inc = 0, cfg_burst = 0;
  logic [1:0]       rd_ch = 0;
  logic [VEC_W-1:0] rd_vec;
  logic [CNT_W-1:0] rd_cnt;
  logic [NSRC-1:0]  pend_q, irq_clr, irq_fwd;
  logic [NSRC-1:0]  raise = 0, drop = 0;
  logic [2:0]       int_mask = 0;
  logic             standby = 0;
  logic             mem_valid, mem_ready, mem_write, busy;
  logic [23:0]      mem_addr;
  logic [1:0]       mem_size;
  logic [31:0]      mem_wdata, mem_rdata;
  logic [3:0]       done_irq;

  irq_dma_engine #(.NSRC(NSRC), .CNT_W(CNT_W)) i_irq_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_vec(cfg_vec),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_size(cfg_size),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_burst(cfg_burst),
    .rd_ch(rd_ch), .rd_vec(rd_vec), .rd_cnt(rd_cnt), .irq_pend(pend_q),
    .irq_clr(irq_clr), .irq_fwd(irq_fwd), .int_mask(int_mask), .standby(standby),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done_irq(done_irq)
  );

  // interrupt source model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~irq_clr & ~drop) | raise;

  // memory model
  logic [7:0] mem [0:255];
  logic [7:0] stall_cnt = 0;
  logic       stall_en = 0;
  always @(posedge clk) stall_cnt <= stall_cnt + 8'd1;
  assign mem_ready = stall_en ? (stall_cnt[1:0] == 2'b11) : 1'b1;
  wire [7:0] a0 = mem_addr[7:0];
  assign mem_rdata = {mem[a0 + 8'd3], mem[a0 + 8'd2], mem[a0 + 8'd1], mem[a0]};

  int rd_n = 0, wr_n = 0, clr_n = 0;
  logic [23:0] rd_log [0:63];
  logic [23:0] wr_log [0:63];
  int done_n [4] = '{0, 0, 0, 0};
  logic busy_seen = 0;

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        for (int b = 0; b < 4; b++)
          if (b < (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4))
            mem[a0 + 8'(b)] <= mem_wdata[8*b +: 8];
        wr_log[wr_n[5:0]] <= mem_addr;
        wr_n <= wr_n + 1;
      end else begin
        rd_log[rd_n[5:0]] <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (|irq_clr) clr_n <= clr_n + 1;
    for (int c = 0; c < 4; c++) if (done_irq[c]) done_n[c] <= done_n[c] + 1;
    if (busy) busy_seen <= 1'b1;
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic arm(input int ch, input int v, input logic [31:0] s, input logic [31:0] d,
                     input int n, input int sz, input bit si, input bit di, input bit bu);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_vec = VEC_W'(v); cfg_src = s; cfg_dst = d;
    cfg_cnt = CNT_W'(n); cfg_size = 2'(sz); cfg_src_inc = si; cfg_dst_inc = di; cfg_burst = bu;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire(input logic [NSRC-1:0] m);
    @(negedge clk); raise = m;
    @(negedge clk); raise = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000 && quiet < 4; i++) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic t_reset();
    check("R12 busy at reset", 32'(busy), 0);
    check("R7 done at reset", 32'(done_irq), 0);
    check("R13 valid at reset", 32'(mem_valid), 0);
    check("R4 clr at reset", irq_clr, 0);
    for (int c = 0; c < 4; c++) begin
      rd_ch = 2'(c); #0;
      check("R1 vector at reset", 32'(rd_vec), 0);
    end
  endtask

  task automatic t_single();
    int c0 = clr_n;
    mem[8'h82] = 8'hEE;
    arm(1, 5, 32'h10, 32'h80, 3, 1, 1, 1, 0);
    fire(32'h1 << 5);
    @(negedge clk);
    check("R12 busy after accept", 32'(busy), 1);
    wait_idle();
    check("R5 low byte", 32'(mem[8'h80]), 32'(mem[8'h10]));
    check("R5 high byte", 32'(mem[8'h81]), 32'(mem[8'h11]));
    check("R5 width kept", 32'(mem[8'h82]), 32'hEE);
    rd_ch = 1; #0;
    check("R6 count decrement", 32'(rd_cnt), 2);
    check("R1 vector kept", 32'(rd_vec), 5);
    check("R6 no completion", 32'(done_n[1]), 0);
    check("R4 pending cleared", 32'(pend_q[5]), 0);
    check("R4 one clear pulse", 32'(clr_n - c0), 1);
  endtask

  task automatic t_complete();
    fire(32'h1 << 5); wait_idle();
    fire(32'h1 << 5); wait_idle();
    check("R5 increment src/dst", {mem[8'h82], mem[8'h85]}, {mem[8'h12], mem[8'h15]});
    check("R7 completion once", 32'(done_n[1]), 1);
    rd_ch = 1; #0;
    check("R7 vector cleared", 32'(rd_vec), 0);
    check("R6 count zero", 32'(rd_cnt), 0);
  endtask

  task automatic t_forward();
    int w0 = wr_n;
    fire(32'h1 << 5);
    repeat (10) @(negedge clk);
    check("R11 forwarded", 32'(irq_fwd[5]), 1);
    check("R11 not consumed", 32'(pend_q[5]), 1);
    check("R1 disarmed no beat", 32'(wr_n - w0), 0);
    @(negedge clk); drop = 32'h1 << 5; @(negedge clk); drop = '0;
  endtask

  task automatic t_mask();
    int w0;
    arm(0, 7, 32'h20, 32'hA0, 1, 0, 1, 1, 0);
    int_mask = 3'd7;
    w0 = wr_n;
    fire(32'h1 << 7);
    repeat (12) @(negedge clk);
    check("R2 held under mask", 32'(wr_n - w0), 0);
    check("R2 still pending", 32'(pend_q[7]), 1);
    check("R11 claimed not forwarded", 32'(irq_fwd[7]), 0);
    int_mask = 3'd3;
    wait_idle();
    check("R2 serviced after mask", 32'(mem[8'hA0]), 32'(mem[8'h20]));
    check("R7 ch0 done", 32'(done_n[0]), 1);
  endtask

  task automatic t_standby();
    int w0;
    arm(0, 8, 32'h24, 32'hA4, 1, 0, 1, 1, 0);
    standby = 1;
    w0 = wr_n;
    fire(32'h1 << 8);
    repeat (12) @(negedge clk);
    check("R3 held in standby", 32'(wr_n - w0), 0);
    check("R3 still pending", 32'(pend_q[8]), 1);
    standby = 0;
    wait_idle();
    check("R3 serviced after standby", 32'(mem[8'hA4]), 32'(mem[8'h24]));
  endtask

  task automatic t_burst();
    int r0 = rd_n, c0 = clr_n;
    bit ok = 1;
    stall_en = 1;
    arm(2, 9, 32'h30, 32'hC0, 4, 2, 1, 1, 1);
    fire(32'h1 << 9);
    wait_idle();
    for (int i = 0; i < 16; i++) if (mem[8'hC0 + 8'(i)] !== mem[8'h30 + 8'(i)]) ok = 0;
    check("R8 sixteen bytes copied", 32'(ok), 1);
    check("R8 four reads", 32'(rd_n - r0), 4);
    check("R8 one clear for burst", 32'(clr_n - c0), 1);
    check("R13 stalled burst done", 32'(done_n[2]), 1);
    stall_en = 0;
  endtask

  task automatic t_prio();
    int r0 = rd_n;
    arm(3, 12, 32'h40, 32'hE0, 1, 0, 1, 1, 0);
    arm(0, 11, 32'h50, 32'hE8, 1, 0, 1, 1, 0);
    fire((32'h1 << 12) | (32'h1 << 11));
    wait_idle();
    check("R9 ch0 first", 32'(rd_log[r0[5:0]]), 32'h50);
    check("R9 ch3 second", 32'(rd_log[6'(r0 + 1)]), 32'h40);
    check("R9 ch3 done", 32'(done_n[3]), 1);
  endtask

  task automatic t_addr();
    int r0 = rd_n, w0 = wr_n;
    arm(1, 14, 32'hAB00_0060, 32'h1234_0070, 1, 0, 1, 1, 0);
    fire(32'h1 << 14);
    wait_idle();
    check("R10 read address", 32'(rd_log[r0[5:0]]), 32'h00_0060);
    check("R10 write address", 32'(wr_log[w0[5:0]]), 32'h34_0070);
    check("R10 data", 32'(mem[8'h70]), 32'(mem[8'h60]));
  endtask

  task automatic t_fixed();
    int r0 = rd_n, w0 = wr_n;
    bit ok = 1;
    stall_en = 1;
    arm(2, 15, 32'h90, 32'h98, 3, 0, 0, 0, 1);
    fire(32'h1 << 15);
    wait_idle();
    check("R5 fixed unit count", 32'(wr_n - w0), 3);
    for (int i = 0; i < 3; i++) begin
      if (rd_log[6'(r0 + i)] !== 24'h90) ok = 0;
      if (wr_log[6'(w0 + i)] !== 24'h98) ok = 0;
    end
    check("R5 fixed addresses", 32'(ok), 1);
    stall_en = 0;
  endtask

  initial begin
    fill();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single();
    t_complete();
    t_forward();
    t_mask();
    t_standby();
    t_burst();
    t_prio();
    t_addr();
    t_fixed();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule